// File: doc/BRIEF.md
# I2C Slave Address Comparator

This block decides whether an I2C slave has been addressed. A slave shift register hands it each completed byte. The block watches START, repeated START and STOP events. It compares the first byte after every START against a locally held slave address. The result is a registered addressed-as-slave flag, `aas`, and a transfer-direction flag, `rw_dir`.

A mode pin selects 7-bit or 10-bit addressing:

- **7-bit mode:** only the seven upper bits of the byte are compared, and the last bit only gives the direction.
- **10-bit mode:** the whole first byte, including its last bit, must equal the stored byte. The second address byte is not compared here; software checks it.
- **Reading in 10-bit mode:** after software confirms the two-byte match, it pulses `rwb_set`. This forces the stored last bit to 1. The header byte with R/W=1 that the master sends after a repeated START then matches, and the slave stays addressed for the read.

Bytes arrive on a valid/ready stream. The block never applies back-pressure: `byte_ready` is always high, and a byte is consumed in every cycle in which `byte_valid` is high. The upstream source may therefore present a byte for exactly one cycle. Holding `byte_valid` high for several cycles delivers several bytes.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `aas` and `rw_dir` are 0 and the stored address byte is 0x00.
- R2: In 7-bit mode (`mode_10b`=0), the first byte after a START matches when its bits [7:1] equal stored bits [7:1]. Bit 0 of either byte does not take part in the comparison.
- R3: In 10-bit mode (`mode_10b`=1), the first byte after a START matches only when all 8 bits equal the stored byte, including bit 0.
- R4: On a match, `rw_dir` takes bit 0 of the received byte (1 = master reads). On a mismatch, `rw_dir` becomes 0. `rw_dir` is never 1 while `aas` is 0.
- R5: Only the first byte consumed after a START is treated as an address. Later bytes leave `aas` and `rw_dir` unchanged until the next START.
- R6: A first byte that does not match clears `aas`, and one that matches sets it.
- R7: `stop_det` clears `aas` and `rw_dir` on the next edge. It also disarms the comparator, so bytes that follow without a new START are ignored.
- R8: `addr_load` writes `addr_wdata` into the stored byte. `rwb_set` forces stored bit 0 to 1. If both are high in the same cycle, `addr_load` wins.
- R9: `byte_ready` is always 1, and a byte is consumed in every cycle in which `byte_valid` is 1.
- R10: A START leaves `aas` unchanged until its address byte arrives. A byte consumed in the same cycle as `start_det` is ignored. `stop_det` takes priority over `start_det`.
- R11: `aas` and `rw_dir` reflect a consumed address byte one clock edge after it is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_det | input | 1 | One-cycle pulse for START or repeated START |
| stop_det | input | 1 | One-cycle pulse for STOP |
| byte_valid | input | 1 | Received byte present |
| byte_ready | output | 1 | Always 1; no back-pressure |
| byte_data | input | 8 | Received byte, MSB first on the wire; bit 0 is R/W |
| mode_10b | input | 1 | 0: 7-bit addressing, 1: 10-bit addressing |
| addr_load | input | 1 | Write `addr_wdata` into the stored address byte |
| addr_wdata | input | 8 | New stored address byte: bits [7:1] address, bit 0 RWB |
| rwb_set | input | 1 | Force stored RWB bit (bit 0) to 1 |
| aas | output | 1 | Addressed-as-slave flag |
| rw_dir | output | 1 | Direction latched from the matched byte, 1 = read |

## Verification
The hardest case to reach is the 10-bit read sequence. The first header byte must match with RWB=0. A second byte must then be ignored. The stored RWB bit must be raised by `rwb_set` while the slave stays addressed. Finally, a repeated START must bring a header with R/W=1 that matches only because of that raised bit.

The bench drives this whole sequence directly. It then replays the final step without the `rwb_set` pulse and expects a mismatch. Same-cycle START-plus-byte and STOP-plus-START collisions are also driven on purpose, to exercise the priority order.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W = 8;
  localparam int RW_BIT = 0;
  typedef logic [BYTE_W-1:0] am_byte_t;
endpackage

// File: rtl/am_addr_reg.sv
module am_addr_reg
  import i2c_am_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  am_byte_t wdata,
  input  logic     set_rwb,
  output am_byte_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (load)    q <= wdata;
    else if (set_rwb) q[RW_BIT] <= 1'b1;
  end

  AST_RWB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_rwb && !load) |=> q[RW_BIT]); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(wdata))); // R8
endmodule

// File: rtl/am_frame_arm.sv
module am_frame_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic byte_fire,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n)         armed <= 1'b0;
    else if (stop_det)  armed <= 1'b0;
    else if (start_det) armed <= 1'b1;
    else if (byte_fire) armed <= 1'b0;
  end

  AST_DISARM_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && byte_fire && !start_det && !stop_det) |=> !armed); // R5
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !armed); // R7
endmodule

// File: rtl/am_compare.sv
module am_compare
  import i2c_am_pkg::*;
(
  input  logic     mode_10b,
  input  am_byte_t rx,
  input  am_byte_t ref_addr,
  output logic     hit
);
  logic [BYTE_W-1:0] bit_eq;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    if (i == RW_BIT) begin : g_rw
      assign bit_eq[i] = !mode_10b || (rx[i] == ref_addr[i]);
    end else begin : g_addr
      assign bit_eq[i] = (rx[i] == ref_addr[i]);
    end
  end

  assign hit = &bit_eq;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              mode_10b,
  input  logic              addr_load,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              rwb_set,
  output logic              aas,
  output logic              rw_dir
);
  am_byte_t addr_q;
  logic     armed;
  logic     hit;
  logic     byte_fire;

  assign byte_ready = 1'b1;
  assign byte_fire  = byte_valid && byte_ready;

  am_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .wdata(addr_wdata),
    .set_rwb(rwb_set), .q(addr_q)
  );

  am_frame_arm u_arm (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_fire(byte_fire), .armed(armed)
  );

  am_compare u_cmp (
    .mode_10b(mode_10b), .rx(byte_data), .ref_addr(addr_q), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aas    <= 1'b0;
      rw_dir <= 1'b0;
    end else if (stop_det) begin
      aas    <= 1'b0;
      rw_dir <= 1'b0;
    end else if (!start_det && byte_fire && armed) begin
      aas    <= hit;
      rw_dir <= hit && byte_data[RW_BIT];
    end
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!aas && !rw_dir)); // R7
  AST_LATE_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && !armed && !start_det && !stop_det) |=> ($stable(aas) && $stable(rw_dir))); // R5
  AST_RW_NEEDS_AAS: assert property (@(posedge clk) disable iff (!rst_n)
    rw_dir |-> aas); // R4
  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> $stable(aas)); // R10
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> byte_ready); // R9
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_det = 1'b0, stop_det = 1'b0, byte_valid = 1'b0;
  logic byte_ready;
  logic [7:0] byte_data = '0;
  logic mode_10b = 1'b0, addr_load = 1'b0, rwb_set = 1'b0;
  logic [7:0] addr_wdata = '0;
  logic aas, rw_dir;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .mode_10b(mode_10b), .addr_load(addr_load), .addr_wdata(addr_wdata),
    .rwb_set(rwb_set), .aas(aas), .rw_dir(rw_dir)
  );

  // {mode, stored, received, exp_aas, exp_rw}
  localparam logic [18:0] VEC [10] = '{
    {1'b0, 8'hA0, 8'hA0, 1'b1, 1'b0},  // R2 write match
    {1'b0, 8'hA0, 8'hA1, 1'b1, 1'b1},  // R2 R4 read match
    {1'b0, 8'hA1, 8'hA0, 1'b1, 1'b0},  // R2 stored bit0 ignored
    {1'b0, 8'hA0, 8'hA2, 1'b0, 1'b0},  // R6 mismatch bit1
    {1'b0, 8'hA0, 8'h20, 1'b0, 1'b0},  // R6 mismatch MSB
    {1'b1, 8'hF2, 8'hF2, 1'b1, 1'b0},  // R3 full match
    {1'b1, 8'hF2, 8'hF3, 1'b0, 1'b0},  // R3 bit0 compared
    {1'b1, 8'hF3, 8'hF3, 1'b1, 1'b1},  // R3 R4 match with bit0=1
    {1'b1, 8'hF6, 8'hF2, 1'b0, 1'b0},  // R3 mismatch
    {1'b1, 8'h00, 8'h00, 1'b1, 1'b0}   // R3 zero address
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic load(input logic [7:0] a);
    @(negedge clk); addr_load = 1'b1; addr_wdata = a;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic set_rwb();
    @(negedge clk); rwb_set = 1'b1;
    @(negedge clk); rwb_set = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 aas", aas, 1'b0);
    chk("R1 rw_dir", rw_dir, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    // R1: stored byte is 0x00 -> 0x00 matches in 10-bit mode
    mode_10b = 1'b1;
    pulse_start(); send(8'h00);
    chk("R1 reset address zero", aas, 1'b1);
    chk("R9 ready", byte_ready, 1'b1);
    pulse_stop();

    for (int i = 0; i < 10; i++) begin
      mode_10b = VEC[i][18];
      load(VEC[i][17:10]);
      pulse_start();
      @(negedge clk); byte_valid = 1'b1; byte_data = VEC[i][9:2];
      @(negedge clk); byte_valid = 1'b0;
      chk($sformatf("R11 R2/R3 aas vec%0d", i), aas, VEC[i][1]);
      chk($sformatf("R4 rw_dir vec%0d", i), rw_dir, VEC[i][0]);
      pulse_stop();
    end

    // R5: later byte ignored after match
    mode_10b = 1'b0; load(8'h50);
    pulse_start(); send(8'h51); send(8'h00);
    chk("R5 aas held", aas, 1'b1);
    chk("R5 rw held", rw_dir, 1'b1);
    // R7: stop clears
    pulse_stop();
    chk("R7 aas cleared", aas, 1'b0);
    chk("R7 rw cleared", rw_dir, 1'b0);
    send(8'h50);
    chk("R7 disarmed", aas, 1'b0);
    // R5: after mismatch, later matching byte ignored
    pulse_start(); send(8'h10); send(8'h50);
    chk("R5 mismatch holds", aas, 1'b0);
    // R6: repeated start with mismatch clears aas
    pulse_start(); send(8'h50);
    chk("R6 set", aas, 1'b1);
    pulse_start();
    chk("R10 start holds aas", aas, 1'b1);
    send(8'h52);
    chk("R6 cleared by mismatch", aas, 1'b0);

    // 10-bit read sequence
    pulse_stop(); mode_10b = 1'b1; load(8'hF2);
    pulse_start(); send(8'hF2); send(8'h3C);
    chk("R3 first byte hit", aas, 1'b1);
    set_rwb();
    chk("R8 aas kept", aas, 1'b1);
    pulse_start(); send(8'hF3);
    chk("R8 read header matches", aas, 1'b1);
    chk("R4 read dir", rw_dir, 1'b1);
    // without rwb_set
    pulse_stop(); load(8'hF2);
    pulse_start(); send(8'hF2); send(8'h3C);
    pulse_start(); send(8'hF3);
    chk("R3 no rwb_set mismatch", aas, 1'b0);

    // R8: load wins over rwb_set
    @(negedge clk); addr_load = 1'b1; addr_wdata = 8'h64; rwb_set = 1'b1;
    @(negedge clk); addr_load = 1'b0; rwb_set = 1'b0;
    pulse_start(); send(8'h65);
    chk("R8 load priority", aas, 1'b0);

    // R10: byte with start same cycle ignored, next byte is the address
    pulse_start(); send(8'h64);
    chk("R10 setup", aas, 1'b1);
    @(negedge clk); start_det = 1'b1; byte_valid = 1'b1; byte_data = 8'h00;
    @(negedge clk); start_det = 1'b0; byte_valid = 1'b0;
    chk("R10 same-cycle byte ignored", aas, 1'b1);
    send(8'h64);
    chk("R10 armed after start", aas, 1'b1);
    // R10: stop beats start
    @(negedge clk); start_det = 1'b1; stop_det = 1'b1;
    @(negedge clk); start_det = 1'b0; stop_det = 1'b0;
    chk("R10 stop priority clears", aas, 1'b0);
    send(8'h64);
    chk("R10 stop priority disarms", aas, 1'b0);

    // R9: back-to-back bytes consumed each cycle
    pulse_start();
    @(negedge clk); byte_valid = 1'b1; byte_data = 8'h64;
    @(negedge clk); byte_data = 8'h00;
    chk("R9 first consumed", aas, 1'b1);
    @(negedge clk); byte_valid = 1'b0;
    chk("R9 second consumed, ignored", aas, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule